// File: doc/BRIEF.md
# Dual-Port Message Register File

This block is a small register file shared by two hosts. A remote bus master reaches it through a slave port. From that port it can fill two message registers and post signal words. It can only read the status registers. A local processor port reads the message registers and owns the response status register. It drains the signal words through a dedicated pop address. Both ports share one 3-bit word address space and carry 16-bit data. Read data on each port is registered, one cycle after the access.

One address answers every read with a fixed protocol identification word. A bus write to that same address does not touch the constant: the word is queued in a small signal FIFO. The response register holds handshake bits that the local side sets and the bus side clears. Whenever the bus reads or writes a message register, the hardware clears the read-ready flag, the write-ready flag and the message-held flag. An access to the high message register also clears a high-half monitor bit. The local side can use that bit to tell a 16-bit message from a 32-bit one. A message interrupt is raised from the ready flags, and an enable bit in the response register chooses its source.

Top module: `msg_port_regs`

## Requirements
- R1: Reads of word address 4 from either port return 16'h1FFF. Writes from either port to that address never change that value.
- R2: A bus write to address 4 pushes its data into a signal FIFO of FIFO_DEPTH entries (default 4). A push into a full FIFO is dropped.
- R3: A local read of address 3 returns the oldest FIFO entry and removes it, so entries come out in push order. A local read of address 3 with the FIFO empty returns 16'h0000 and changes nothing.
- R4: Response bit 4 reads 1 while the FIFO holds at least one entry, and 0 when it is empty.
- R5: Bus writes to the response register (address 5) have no effect.
- R6: A local write to address 5 stores the writable bits, mask 16'h3EEF. Bit 15 always reads 0 and bits 14 and 8 always read 1. Bit 4 is driven only by the FIFO state.
- R7: A bus read or write of message low (address 6) clears response bits 10 (read-ready), 9 (write-ready) and 3 (message-held), and leaves bit 5 alone.
- R8: A bus read or write of message high (address 7) clears bits 10, 9 and 3, and also bit 5 (high-half monitor).
- R9: Bus writes to addresses 6 and 7 load the message registers, which both ports read back.
- R10: With bit 6 clear, msg_irq is the inverse of bit 9. With bit 6 set, msg_irq is high when bit 9 or bit 10 is low.
- R11: After reset the response register reads 16'h4100, the FIFO is empty and msg_irq is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus port access strobe, one cycle per access |
| bus_we | input | 1 | Bus port write (1) or read (0) |
| bus_addr | input | 3 | Bus port word address |
| bus_wdata | input | 16 | Bus port write data |
| bus_rdata | output | 16 | Bus port registered read data |
| loc_sel | input | 1 | Local port access strobe |
| loc_we | input | 1 | Local port write (1) or read (0) |
| loc_addr | input | 3 | Local port word address |
| loc_wdata | input | 16 | Local port write data |
| loc_rdata | output | 16 | Local port registered read data |
| msg_irq | output | 1 | Message interrupt, registered |

## Verification
The bench goes after the shared protocol address. A design that decoded writes there as ordinary storage would corrupt the constant read back after a signal push. It fills the FIFO one past its depth and drains it with an extra pop. Wrapping pointers or a missing full guard would overwrite the oldest word, and a missing empty guard would return stale data. It touches each message register from the bus with every handshake bit set and reads the response word back. A decoder that confused the low and high halves would clear the monitor bit in the wrong case. The interrupt is stepped through both settings of the enable bit, including a hardware clear. A design that ignored the enable, or ORed the flags in the wrong sense, would hold msg_irq at the wrong level.

// File: rtl/msgif_pkg.sv
package msgif_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_POP    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PROTO  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RESP   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_MSG_LO = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_MSG_HI = 3'd7;

  localparam logic [REG_W-1:0] PROTO_ID   = 16'h1FFF;
  localparam logic [REG_W-1:0] RESP_WMASK = 16'h3EEF;
  localparam logic [REG_W-1:0] RESP_CONST = 16'h4100;

  // response bit positions the hardware acts on
  localparam int B_RD_RDY   = 10;
  localparam int B_WR_RDY   = 9;
  localparam int B_RR_IEN   = 6;
  localparam int B_HI_TOUCH = 5;
  localparam int B_SIG_PEND = 4;
  localparam int B_MSG_HELD = 3;
endpackage

// File: rtl/msgif_sig_fifo.sv
module msgif_sig_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign not_empty = (cnt != '0);
  assign full      = (cnt == CW'(DEPTH));
  assign head      = mem[rd_ptr];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2: a full queue refusing a push stays full
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
  // R3: popping an empty queue leaves it empty
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && pop && !push) |=> !not_empty);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/msgif_resp_reg.sv
module msgif_resp_reg
  import msgif_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             loc_wr,
  input  logic [REG_W-1:0] loc_wdata,
  input  logic             clr_any,
  input  logic             clr_hi,
  input  logic             sig_pend,
  output logic [REG_W-1:0] resp_word,
  output logic             irq
);
  logic [REG_W-1:0] store_q, store_d;
  logic             irq_d;

  always_comb begin
    store_d = store_q;
    if (loc_wr) store_d = loc_wdata & RESP_WMASK;
    // hardware clear from the bus side wins over a local write
    if (clr_any) begin
      store_d[B_RD_RDY]   = 1'b0;
      store_d[B_WR_RDY]   = 1'b0;
      store_d[B_MSG_HELD] = 1'b0;
    end
    if (clr_hi) store_d[B_HI_TOUCH] = 1'b0;
    irq_d = !store_d[B_WR_RDY] || (store_d[B_RR_IEN] && !store_d[B_RD_RDY]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      irq     <= 1'b1;
    end else begin
      store_q <= store_d;
      irq     <= irq_d;
    end
  end

  always_comb begin
    resp_word = (store_q & RESP_WMASK) | RESP_CONST;
    resp_word[B_SIG_PEND] = sig_pend;
  end

  // R7: any message access by the bus drops the handshake flags
  a_r7_hw_clear: assert property (@(posedge clk) disable iff (rst)
    clr_any |=> (!resp_word[B_RD_RDY] && !resp_word[B_WR_RDY] && !resp_word[B_MSG_HELD]));
  // R8: a high-half access drops the monitor bit
  a_r8_hi_clear: assert property (@(posedge clk) disable iff (rst)
    clr_hi |=> !resp_word[B_HI_TOUCH]);
  // R6: without a write or clear the stored bits hold
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!loc_wr && !clr_any && !clr_hi) |=> $stable(store_q));
  // R10: the registered interrupt tracks the visible flags
  a_r10_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq == (!resp_word[B_WR_RDY] || (resp_word[B_RR_IEN] && !resp_word[B_RD_RDY])));
endmodule

// File: rtl/msg_port_regs.sv
module msg_port_regs
  import msgif_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              loc_sel,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [REG_W-1:0]  loc_wdata,
  output logic [REG_W-1:0]  loc_rdata,
  output logic              msg_irq
);
  logic bus_rd, bus_wr, loc_rd, loc_wr;
  logic bus_touch_lo, bus_touch_hi, sig_push, sig_pop;
  logic [REG_W-1:0] msg_lo_q, msg_hi_q, resp_word, sig_head;
  logic sig_nempty, sig_full;

  assign bus_rd = bus_sel && !bus_we;
  assign bus_wr = bus_sel && bus_we;
  assign loc_rd = loc_sel && !loc_we;
  assign loc_wr = loc_sel && loc_we;

  assign bus_touch_lo = bus_sel && (bus_addr == ADR_MSG_LO);
  assign bus_touch_hi = bus_sel && (bus_addr == ADR_MSG_HI);
  assign sig_push     = bus_wr && (bus_addr == ADR_PROTO);
  assign sig_pop      = loc_rd && (loc_addr == ADR_POP);

  msgif_sig_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_sig_fifo (
    .clk(clk), .rst(rst),
    .push(sig_push), .push_data(bus_wdata),
    .pop(sig_pop), .head(sig_head),
    .not_empty(sig_nempty), .full(sig_full)
  );

  msgif_resp_reg u_resp (
    .clk(clk), .rst(rst),
    .loc_wr(loc_wr && (loc_addr == ADR_RESP)),
    .loc_wdata(loc_wdata),
    .clr_any(bus_touch_lo || bus_touch_hi),
    .clr_hi(bus_touch_hi),
    .sig_pend(sig_nempty),
    .resp_word(resp_word),
    .irq(msg_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_lo_q <= '0;
      msg_hi_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_MSG_LO) msg_lo_q <= bus_wdata;
      if (bus_addr == ADR_MSG_HI) msg_hi_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADR_PROTO:  bus_rdata <= PROTO_ID;
        ADR_RESP:   bus_rdata <= resp_word;
        ADR_MSG_LO: bus_rdata <= msg_lo_q;
        ADR_MSG_HI: bus_rdata <= msg_hi_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_rdata <= '0;
    end else if (loc_rd) begin
      case (loc_addr)
        ADR_POP:    loc_rdata <= sig_nempty ? sig_head : '0;
        ADR_PROTO:  loc_rdata <= PROTO_ID;
        ADR_RESP:   loc_rdata <= resp_word;
        ADR_MSG_LO: loc_rdata <= msg_lo_q;
        ADR_MSG_HI: loc_rdata <= msg_hi_q;
        default:    loc_rdata <= '0;
      endcase
    end
  end

  // R1: the protocol word is returned on either port
  a_r1_proto_bus: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_PROTO) |=> (bus_rdata == PROTO_ID));
  a_r1_proto_loc: assert property (@(posedge clk) disable iff (rst)
    (loc_rd && loc_addr == ADR_PROTO) |=> (loc_rdata == PROTO_ID));
  // R3: a pop of an empty queue reads zero
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (sig_pop && !sig_nempty) |=> (loc_rdata == '0));
  // R4: a push always leaves something pending
  a_r4_sig_after_push: assert property (@(posedge clk) disable iff (rst)
    (sig_push && !sig_pop) |=> resp_word[B_SIG_PEND]);
endmodule

// File: tb/test_msg_port_regs.sv
`timescale 1ns/1ps
module test_msg_port_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        loc_sel = 1'b0, loc_we = 1'b0;
  logic [2:0]  loc_addr = '0;
  logic [15:0] loc_wdata = '0;
  logic [15:0] loc_rdata;
  logic        msg_irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  msg_port_regs i_msg_port_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .loc_sel(loc_sel), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .msg_irq(msg_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic loc_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); loc_sel = 1'b1; loc_we = 1'b1; loc_addr = a; loc_wdata = d;
    @(negedge clk); loc_sel = 1'b0; loc_we = 1'b0;
  endtask

  task automatic loc_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); loc_sel = 1'b1; loc_we = 1'b0; loc_addr = a;
    @(negedge clk); loc_sel = 1'b0; d = loc_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    loc_read(3'd5, v);
    check("R11 response after reset", v, 16'h4100);
    check("R11 irq after reset", {15'd0, msg_irq}, 16'h0001);
    loc_read(3'd3, v);
    check("R11 fifo empty after reset", v, 16'h0000);
  endtask

  task automatic t_proto;
    logic [15:0] v;
    bus_read(3'd4, v);
    check("R1 bus protocol read", v, 16'h1FFF);
    loc_write(3'd4, 16'h0000);
    loc_read(3'd4, v);
    check("R1 local protocol read after local write", v, 16'h1FFF);
  endtask

  task automatic t_fifo;
    logic [15:0] v;
    bus_write(3'd4, 16'hA001);
    bus_write(3'd4, 16'hA002);
    bus_read(3'd4, v);
    check("R1 protocol unchanged by push", v, 16'h1FFF);
    loc_read(3'd5, v);
    check("R4 pending bit set", v, 16'h4110);
    loc_read(3'd3, v);
    check("R3 first pop", v, 16'hA001);
    loc_read(3'd3, v);
    check("R3 second pop", v, 16'hA002);
    loc_read(3'd3, v);
    check("R3 pop empty", v, 16'h0000);
    loc_read(3'd5, v);
    check("R4 pending bit clear", v, 16'h4100);
  endtask

  task automatic t_fill;
    logic [15:0] v;
    for (int i = 1; i <= 5; i++) bus_write(3'd4, 16'h1000 + 16'(i));
    for (int i = 1; i <= 4; i++) begin
      loc_read(3'd3, v);
      check("R2 fill order", v, 16'h1000 + 16'(i));
    end
    loc_read(3'd3, v);
    check("R2 push into full dropped", v, 16'h0000);
  endtask

  task automatic t_resp_rw;
    logic [15:0] v;
    loc_write(3'd5, 16'hFFFF);
    loc_read(3'd5, v);
    check("R6 local write mask", v, 16'h7FEF);
    bus_write(3'd5, 16'h0000);
    loc_read(3'd5, v);
    check("R5 bus write ignored", v, 16'h7FEF);
    bus_read(3'd5, v);
    check("R5 bus read of response", v, 16'h7FEF);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    loc_write(3'd5, 16'hFFFF);
    bus_read(3'd6, v);
    loc_read(3'd5, v);
    check("R7 low access clears flags", v, 16'h79E7);
    loc_write(3'd5, 16'hFFFF);
    bus_write(3'd7, 16'h5555);
    loc_read(3'd5, v);
    check("R8 high access clears monitor", v, 16'h79C7);
  endtask

  task automatic t_msg;
    logic [15:0] v;
    bus_write(3'd6, 16'h1234);
    bus_write(3'd7, 16'hABCD);
    loc_read(3'd6, v);
    check("R9 message low", v, 16'h1234);
    loc_read(3'd7, v);
    check("R9 message high", v, 16'hABCD);
    bus_read(3'd7, v);
    check("R9 bus read message high", v, 16'hABCD);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    loc_write(3'd5, 16'h0000);
    check("R10 wr flag low", {15'd0, msg_irq}, 16'h0001);
    loc_write(3'd5, 16'h0200);
    check("R10 wr flag high enable off", {15'd0, msg_irq}, 16'h0000);
    loc_write(3'd5, 16'h0240);
    check("R10 rd flag low enable on", {15'd0, msg_irq}, 16'h0001);
    loc_write(3'd5, 16'h0640);
    check("R10 both flags high", {15'd0, msg_irq}, 16'h0000);
    loc_write(3'd5, 16'h0400);
    check("R10 rd high wr low", {15'd0, msg_irq}, 16'h0001);
    loc_write(3'd5, 16'h0640);
    bus_read(3'd6, v);
    check("R10 irq after hw clear", {15'd0, msg_irq}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_proto();
    t_fifo();
    t_fill();
    t_resp_rw();
    t_clear();
    t_msg();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule